// File: doc/BRIEF.md
# Calendar Clock With Update Cycle

This block keeps the time of day and the calendar date (seconds, minutes, hours, day of week, day of month, month and a two-digit year) for a system that only needs a once-per-second strobe and a 32 kHz strobe to run it. Each accepted second strobe starts an update. In the first phase, the update-in-progress flag goes high and a private time counter steps forward with full calendar carries. After eight 32 kHz strobes, the second phase fires in a single cycle. It refreshes the visible time registers, checks the alarm and signals the end of the update. Because the visible time changes in one cycle, a reader never sees a half-updated value.

Software reaches the registers through a simple indexed write port and a read port with one cycle of latency. The visible registers can show values in BCD or in plain binary. Hours can be shown in 24-hour form or in 12-hour form, with a PM flag in bit 7. A hold mode freezes the visible registers so that software can load a new time. When a time register is written, or when hold mode is released, the register contents are decoded back into the private counter.

Register indices (4 bits): 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week (0..6), 7 day of month, 8 month (1..12), 9 year (two digits, the century taken from `BASE_YEAR`), 10 control A, 11 control B, 12 event flags, 13 status (always reads 0x80). Other indices read 0.

Top module: `cal_clock`

## Requirements
- R1: After reset the visible registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x06, day of month 0x01, month 0x01 and year 0x00. Control A reads 0x26, control B reads 0x02, the flag register reads 0x00 and `irq` is low.
- R2: A second strobe is accepted only when bits 6..4 of control A equal 3'b010. With any other value in that field the strobe is ignored: the time does not move and the update-in-progress flag (bit 7 of control A) stays clear.
- R3: Each accepted second advances the time with full carries from seconds through minutes, hours, day, month and year. The day of week wraps from 6 to 0, and the year wraps from 99 to 00.
- R4: Month lengths follow the Gregorian rules: 30 or 31 days by month, and February has 29 days when the full year is divisible by 4 and either not divisible by 100 or divisible by 400 (2000 and 2024 are leap years, 2023 is not).
- R5: Bit 7 of control A reads 1 from the accepted second strobe until the eighth 32 kHz strobe that follows it, and reads 0 after that. The visible time keeps its old value until that eighth strobe and shows the new value after it.
- R6: Setting bit 7 of control B (hold) clears update-in-progress and keeps it clear. While hold is set, the update phase leaves the visible time registers unchanged and host writes to them are not decoded. Writing control B with bit 7 clear while hold is set loads the register contents into the time counter.
- R7: Bit 2 of control B selects binary (1) or BCD (0) for every time and alarm byte, both when values are written and when they are shown.
- R8: Bit 1 of control B selects 24-hour (1) or 12-hour (0) form. In 12-hour form the hours byte holds 1..12, with bit 7 set for PM. Midnight shows as 12 with bit 7 clear, noon as 12 with bit 7 set, and a written 12 with bit 7 clear decodes to hour 0.
- R9: With bit 5 of control B set, the update phase compares each of the seconds, minutes and hours alarm bytes with the byte that field shows in the current format. An alarm byte with bits 7 and 6 both set matches any value. When all three match, flag bits 7 and 5 are set and `irq` goes high. With bit 5 clear, no alarm flag is raised.
- R10: With bit 4 of control B set, every update phase sets flag bits 7 and 4 and raises `irq`.
- R11: Reading the flag register (index 12) returns the flags and clears them and `irq`, so the next read returns 0x00.
- R12: Writes to indices 12 and 13 are ignored, index 13 always reads 0x80, and bit 7 of control A cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sec | input | 1 | One-cycle strobe, once per second |
| tick_32k | input | 1 | One-cycle strobe at 32 kHz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register index for the read |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request, high while a flag is pending |

## Verification
The assertions assume the following about the inputs. A second strobe never arrives while an update is still waiting for its eighth 32 kHz strobe. Host writes never fall in the same cycle as a second strobe or a 32 kHz strobe. Written time bytes are valid for the selected format. The bench meets these assumptions by issuing every strobe and every register access from separate tasks that run one after another, with each strobe a single cycle long. All eight 32 kHz strobes of an update are always delivered before the next register access or second strobe.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int ADDR_W        = 4;
  localparam int NUM_TIME_REGS = 10;

  localparam int IX_SEC     = 0;
  localparam int IX_SEC_AL  = 1;
  localparam int IX_MIN     = 2;
  localparam int IX_MIN_AL  = 3;
  localparam int IX_HOUR    = 4;
  localparam int IX_HOUR_AL = 5;
  localparam int IX_WDAY    = 6;
  localparam int IX_MDAY    = 7;
  localparam int IX_MON     = 8;
  localparam int IX_YEAR    = 9;
  localparam int IX_CTRL_A  = 10;
  localparam int IX_CTRL_B  = 11;
  localparam int IX_FLAGS   = 12;
  localparam int IX_STATUS  = 13;

  typedef struct packed {
    logic [7:0] yoff;   // years since BASE_YEAR
    logic [3:0] mon;    // 1..12
    logic [4:0] mday;   // 1..31
    logic [2:0] wday;   // 0..6
    logic [4:0] hour;   // 0..23
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  // Value (0..99) to register byte in the chosen encoding.
  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  // Register byte to value in the chosen encoding.
  function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
    if (bin) return b;
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    logic [7:0] e;
    if (h24) return enc_val({2'b00, h}, bin);
    if (h == 5'd0)       h12 = 5'd12;
    else if (h > 5'd12)  h12 = h - 5'd12;
    else                 h12 = h;
    e = enc_val({2'b00, h12}, bin);
    return {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
    logic [7:0] v;
    if (h24) begin
      v = dec_val(b, bin);
      return v[4:0];
    end
    v = dec_val({1'b0, b[6:0]}, bin);
    if (v == 8'd12) return b[7] ? 5'd12 : 5'd0;
    return b[7] ? (v[4:0] + 5'd12) : v[4:0];
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [11:0] yr);
    logic leap;
    leap = (yr % 12'd4 == 12'd0) && ((yr % 12'd100 != 12'd0) || (yr % 12'd400 == 12'd0));
    case (mon)
      4'd2:                    return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_next_second.sv
module cal_next_second
  import cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  cal_time_t cur,
  output cal_time_t nxt
);

  logic [11:0] full_year;
  logic [4:0]  dim;

  assign full_year = 12'(BASE_YEAR) + {4'd0, cur.yoff};
  assign dim       = days_in_month(cur.mon, full_year);

  always_comb begin
    nxt = cur;
    if (cur.sec >= 6'd59) begin
      nxt.sec = '0;
      if (cur.min >= 6'd59) begin
        nxt.min = '0;
        if (cur.hour >= 5'd23) begin
          nxt.hour = '0;
          nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
          if (cur.mday >= dim || cur.mday == 5'd0) begin
            nxt.mday = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon  = 4'd1;
              nxt.yoff = cur.yoff + 8'd1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur.mday + 5'd1;
          end
        end else begin
          nxt.hour = cur.hour + 5'd1;
        end
      end else begin
        nxt.min = cur.min + 6'd1;
      end
    end else begin
      nxt.sec = cur.sec + 6'd1;
    end
  end

endmodule

// File: rtl/cal_update_seq.sv
module cal_update_seq #(
  parameter int DELAY_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_sec,
  input  logic tick_32k,
  input  logic osc_run,
  output logic advance,
  output logic fire,
  output logic busy
);

  localparam int CW = $clog2(DELAY_TICKS + 1);

  logic [CW-1:0] cnt;

  assign advance = tick_sec & osc_run & ~busy;
  assign fire    = busy & tick_32k & (cnt == CW'(DELAY_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (advance) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick_32k) begin
      if (fire) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int DELAY_TICKS = 8,
  parameter int BASE_YEAR   = 2000,
  parameter int RESET_WDAY  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_sec,
  input  logic              tick_32k,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);

  localparam int NTR = NUM_TIME_REGS;

  logic [7:0] tregs [NTR];
  logic [7:0] mreg  [NTR];
  logic [6:0] ctl_a;
  logic [7:0] ctl_b;
  logic       uip;
  logic       fl_irq, fl_al, fl_up;
  cal_time_t  cur, nxt, dec_t;

  logic advance, fire, busy, osc_run;
  logic bin, h24, set_mode;
  logic [7:0] mb;
  logic is_time_wr, set_release, load, wr_b, rd_flags;
  logic [7:0] v_sec, v_min, v_hour, v_wday, v_mday, v_mon, v_year;
  logic alarm_hit;

  assign osc_run  = (ctl_a[6:4] == 3'b010);
  assign bin      = ctl_b[2];
  assign h24      = ctl_b[1];
  assign set_mode = ctl_b[7];
  assign irq      = fl_irq;

  cal_update_seq #(.DELAY_TICKS(DELAY_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick_sec(tick_sec), .tick_32k(tick_32k),
    .osc_run(osc_run), .advance(advance), .fire(fire), .busy(busy)
  );

  cal_next_second #(.BASE_YEAR(BASE_YEAR)) u_next (
    .cur(cur), .nxt(nxt)
  );

  // Register contents as they stand after a pending write, for decoding.
  assign wr_b = wr_en && (wr_addr == ADDR_W'(IX_CTRL_B));
  assign mb   = wr_b ? wr_data : ctl_b;

  always_comb begin
    for (int i = 0; i < NTR; i++)
      mreg[i] = (wr_en && wr_addr == ADDR_W'(i)) ? wr_data : tregs[i];
  end

  always_comb begin
    logic [7:0] t;
    dec_t = cur;
    t = dec_val(mreg[IX_SEC], mb[2]);  dec_t.sec  = t[5:0];
    t = dec_val(mreg[IX_MIN], mb[2]);  dec_t.min  = t[5:0];
    dec_t.hour = dec_hour(mreg[IX_HOUR], mb[2], mb[1]);
    t = dec_val(mreg[IX_WDAY], mb[2]); dec_t.wday = t[2:0];
    t = dec_val(mreg[IX_MDAY], mb[2]); dec_t.mday = t[4:0];
    t = dec_val(mreg[IX_MON], mb[2]);  dec_t.mon  = t[3:0];
    dec_t.yoff = dec_val(mreg[IX_YEAR], mb[2]);
  end

  always_comb begin
    is_time_wr = 1'b0;
    if (wr_en) begin
      case (int'(wr_addr))
        IX_SEC, IX_MIN, IX_HOUR, IX_WDAY, IX_MDAY, IX_MON, IX_YEAR: is_time_wr = 1'b1;
        default: is_time_wr = 1'b0;
      endcase
    end
  end

  assign set_release = wr_b && !wr_data[7] && set_mode;
  assign load        = (is_time_wr && !set_mode) || set_release;
  assign rd_flags    = rd_en && (rd_addr == ADDR_W'(IX_FLAGS));

  // Current time in the selected display format.
  always_comb begin
    logic [7:0] yy;
    yy     = cur.yoff % 8'd100;
    v_sec  = enc_val({1'b0, cur.sec}, bin);
    v_min  = enc_val({1'b0, cur.min}, bin);
    v_hour = enc_hour(cur.hour, bin, h24);
    v_wday = enc_val({4'd0, cur.wday}, bin);
    v_mday = enc_val({2'd0, cur.mday}, bin);
    v_mon  = enc_val({3'd0, cur.mon}, bin);
    v_year = enc_val(yy[6:0], bin);
  end

  function automatic logic al_match(input logic [7:0] al, input logic [7:0] v);
    return (al[7:6] == 2'b11) || (al == v);
  endfunction

  assign alarm_hit = ctl_b[5] && al_match(tregs[IX_SEC_AL], v_sec)
                   && al_match(tregs[IX_MIN_AL], v_min) && al_match(tregs[IX_HOUR_AL], v_hour);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '{yoff: 8'd0, mon: 4'd1, mday: 5'd1, wday: 3'(RESET_WDAY),
                    hour: 5'd0, min: 6'd0, sec: 6'd0};
    end else if (advance) begin
      cur <= nxt;
    end else if (load) begin
      cur <= dec_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTR; i++) tregs[i] <= 8'h00;
      tregs[IX_WDAY] <= 8'(RESET_WDAY);
      tregs[IX_MDAY] <= 8'h01;
      tregs[IX_MON]  <= 8'h01;
    end else begin
      if (fire && !set_mode) begin
        tregs[IX_SEC]  <= v_sec;
        tregs[IX_MIN]  <= v_min;
        tregs[IX_HOUR] <= v_hour;
        tregs[IX_WDAY] <= v_wday;
        tregs[IX_MDAY] <= v_mday;
        tregs[IX_MON]  <= v_mon;
        tregs[IX_YEAR] <= v_year;
      end
      for (int i = 0; i < NTR; i++)
        if (wr_en && wr_addr == ADDR_W'(i)) tregs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= 7'h26;
      ctl_b <= 8'h02;
      uip   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(IX_CTRL_A)) ctl_a <= wr_data[6:0];
      if (wr_b) ctl_b <= wr_data;
      if (advance && !set_mode) uip <= 1'b1;
      if (fire) uip <= 1'b0;
      if (wr_b && wr_data[7]) uip <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_irq <= 1'b0;
      fl_al  <= 1'b0;
      fl_up  <= 1'b0;
    end else begin
      if (rd_flags) begin
        fl_irq <= 1'b0;
        fl_al  <= 1'b0;
        fl_up  <= 1'b0;
      end
      if (fire && alarm_hit) begin
        fl_irq <= 1'b1;
        fl_al  <= 1'b1;
      end
      if (fire && ctl_b[4]) begin
        fl_irq <= 1'b1;
        fl_up  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (rd_en) begin
      rd_data <= 8'h00;
      for (int i = 0; i < NTR; i++)
        if (rd_addr == ADDR_W'(i)) rd_data <= tregs[i];
      if (rd_addr == ADDR_W'(IX_CTRL_A)) rd_data <= {uip, ctl_a};
      if (rd_addr == ADDR_W'(IX_CTRL_B)) rd_data <= ctl_b;
      if (rd_addr == ADDR_W'(IX_FLAGS))  rd_data <= {fl_irq, 1'b0, fl_al, fl_up, 4'h0};
      if (rd_addr == ADDR_W'(IX_STATUS)) rd_data <= 8'h80;
    end
  end

endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      wr_en,
  input logic      irq,
  input logic      fire,
  input logic      uip,
  input logic      set_mode,
  input logic      osc_run,
  input logic      load,
  input logic      fl_al,
  input logic      fl_up,
  input logic [7:0] shown_sec,
  input cal_time_t cur_time
);

  // R2: a stopped oscillator field freezes the counter unless the host loads it
  p_osc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!osc_run && !load) |=> $stable(cur_time));

  // R5: the visible seconds only move at the update phase or on a host write
  p_shown_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!fire && !wr_en) |=> $stable(shown_sec));

  // R5: update-in-progress is low right after the update phase
  p_uip_drop_r5: assert property (@(posedge clk) disable iff (rst)
    fire |=> !uip);

  // R6: hold mode keeps update-in-progress clear
  p_uip_hold_r6: assert property (@(posedge clk) disable iff (rst)
    set_mode |-> !uip);

  // R9, R10: the interrupt only rises from an update phase
  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(fire));

  // R11: a pending interrupt always has a flag behind it
  p_irq_flags_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fl_al || fl_up));

endmodule

bind cal_clock cal_clock_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq(irq), .fire(fire), .uip(uip),
  .set_mode(set_mode), .osc_run(osc_run), .load(load), .fl_al(fl_al),
  .fl_up(fl_up), .shown_sec(tregs[0]), .cur_time(cur)
);

// File: tb/cal_clock_test.sv
module cal_clock_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_sec = 1'b0;
  logic       tick_32k = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cal_clock uut (
    .clk(clk), .rst(rst), .tick_sec(tick_sec), .tick_32k(tick_32k),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic sec_strobe();
    @(negedge clk); tick_sec = 1'b1;
    @(negedge clk); tick_sec = 1'b0;
  endtask

  task automatic fast_strobes(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_second();
    sec_strobe();
    fast_strobes(8);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] wd, input logic [7:0] md,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
    wr(4'd6, wd); wr(4'd7, md); wr(4'd8, mo); wr(4'd9, yr);
  endtask

  task automatic t_reset();
    rd_chk("R1 sec", 4'd0, 8'h00);
    rd_chk("R1 min", 4'd2, 8'h00);
    rd_chk("R1 hour", 4'd4, 8'h00);
    rd_chk("R1 wday", 4'd6, 8'h06);
    rd_chk("R1 mday", 4'd7, 8'h01);
    rd_chk("R1 month", 4'd8, 8'h01);
    rd_chk("R1 year", 4'd9, 8'h00);
    rd_chk("R1 ctrl A", 4'd10, 8'h26);
    rd_chk("R1 ctrl B", 4'd11, 8'h02);
    rd_chk("R1 flags", 4'd12, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_update_phase();
    sec_strobe();
    rd_chk("R5 uip after strobe", 4'd10, 8'hA6);
    fast_strobes(7);
    rd_chk("R5 sec before copy", 4'd0, 8'h00);
    rd_chk("R5 uip after 7", 4'd10, 8'hA6);
    fast_strobes(1);
    rd_chk("R5 uip cleared", 4'd10, 8'h26);
    rd_chk("R5 sec after copy", 4'd0, 8'h01);
  endtask

  task automatic t_osc_stop();
    wr(4'd10, 8'h06);
    sec_strobe();
    rd_chk("R2 no uip", 4'd10, 8'h06);
    fast_strobes(8);
    rd_chk("R2 sec frozen", 4'd0, 8'h01);
    wr(4'd10, 8'h26);
    run_second();
    rd_chk("R2 sec resumes", 4'd0, 8'h02);
  endtask

  task automatic t_carry();
    set_time(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h99);
    run_second();
    rd_chk("R3 sec", 4'd0, 8'h00);
    rd_chk("R3 min", 4'd2, 8'h00);
    rd_chk("R3 hour", 4'd4, 8'h00);
    rd_chk("R3 wday wrap", 4'd6, 8'h00);
    rd_chk("R3 mday", 4'd7, 8'h01);
    rd_chk("R3 month", 4'd8, 8'h01);
    rd_chk("R3 year wrap", 4'd9, 8'h00);
  endtask

  task automatic t_leap();
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
    run_second();
    rd_chk("R4 2000 feb29 day", 4'd7, 8'h29);
    rd_chk("R4 2000 feb29 mon", 4'd8, 8'h02);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    run_second();
    rd_chk("R4 2023 mar1 day", 4'd7, 8'h01);
    rd_chk("R4 2023 mar1 mon", 4'd8, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    run_second();
    rd_chk("R4 2024 feb29", 4'd7, 8'h29);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h24);
    run_second();
    rd_chk("R4 apr30 day", 4'd7, 8'h01);
    rd_chk("R4 apr30 mon", 4'd8, 8'h05);
  endtask

  task automatic t_hold();
    set_time(8'h10, 8'h20, 8'h05, 8'h02, 8'h10, 8'h06, 8'h24);
    wr(4'd11, 8'h82);
    wr(4'd0, 8'h30);
    sec_strobe();
    rd_chk("R6 no uip in hold", 4'd10, 8'h26);
    fast_strobes(8);
    rd_chk("R6 shown frozen", 4'd0, 8'h30);
    wr(4'd11, 8'h02);
    run_second();
    rd_chk("R6 loaded on release", 4'd0, 8'h31);
    rd_chk("R6 min kept", 4'd2, 8'h20);
  endtask

  task automatic t_binary();
    wr(4'd11, 8'h06);
    set_time(8'h0A, 8'h3B, 8'h3B, 8'h02, 8'h0A, 8'h06, 8'h18);
    run_second();
    rd_chk("R7 bin hour", 4'd4, 8'h0B);
    rd_chk("R7 bin min", 4'd2, 8'h00);
    rd_chk("R7 bin sec", 4'd0, 8'h00);
    wr(4'd11, 8'h02);
    run_second();
    rd_chk("R7 bcd hour", 4'd4, 8'h11);
    rd_chk("R7 bcd sec", 4'd0, 8'h01);
  endtask

  task automatic t_twelve();
    wr(4'd11, 8'h00);
    set_time(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h24);
    run_second();
    rd_chk("R8 midnight", 4'd4, 8'h12);
    set_time(8'h11, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h24);
    run_second();
    rd_chk("R8 noon", 4'd4, 8'h92);
    set_time(8'h12, 8'h10, 8'h10, 8'h02, 8'h10, 8'h06, 8'h24);
    run_second();
    rd_chk("R8 12am stays", 4'd4, 8'h12);
    wr(4'd11, 8'h02);
    run_second();
    rd_chk("R8 12am is hour0", 4'd4, 8'h00);
  endtask

  task automatic t_alarm();
    wr(4'd11, 8'h22);
    wr(4'd1, 8'h05); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    set_time(8'h14, 8'h20, 8'h04, 8'h02, 8'h10, 8'h06, 8'h24);
    run_second();
    check("R9 irq on match", {7'd0, irq}, 8'h01);
    rd_chk("R9 alarm flags", 4'd12, 8'hA0);
    rd_chk("R11 flags cleared", 4'd12, 8'h00);
    check("R11 irq cleared", {7'd0, irq}, 8'h00);
    run_second();
    rd_chk("R9 no match", 4'd12, 8'h00);
    wr(4'd1, 8'h10); wr(4'd3, 8'h20); wr(4'd5, 8'h15);
    wr(4'd0, 8'h09);
    run_second();
    rd_chk("R9 hour mismatch", 4'd12, 8'h00);
    wr(4'd5, 8'h14);
    wr(4'd0, 8'h09);
    run_second();
    rd_chk("R9 exact match", 4'd12, 8'hA0);
    wr(4'd11, 8'h02);
    wr(4'd0, 8'h09);
    run_second();
    rd_chk("R9 disabled", 4'd12, 8'h00);
  endtask

  task automatic t_update_ended();
    wr(4'd11, 8'h12);
    run_second();
    check("R10 irq", {7'd0, irq}, 8'h01);
    rd_chk("R10 flags", 4'd12, 8'h90);
    wr(4'd11, 8'h02);
  endtask

  task automatic t_readonly();
    wr(4'd12, 8'hFF);
    rd_chk("R12 flags not writable", 4'd12, 8'h00);
    wr(4'd13, 8'h00);
    rd_chk("R12 status", 4'd13, 8'h80);
    wr(4'd10, 8'hA6);
    rd_chk("R12 uip read-only", 4'd10, 8'h26);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_update_phase();
    t_osc_stop();
    t_carry();
    t_leap();
    t_hold();
    t_binary();
    t_twelve();
    t_alarm();
    t_update_ended();
    t_readonly();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule